// File: doc/BRIEF.md
# Seconds Real-Time Clock with Calibrated Prescaler

This core keeps time as a 32-bit count of seconds. A slow enable at crystal rate drives a programmable tick prescaler. Each time the prescaler completes a calibrated period, it produces a one-second tick. An optional fractional correction stretches some seconds by one enable period. This lets long-term drift be trimmed below the resolution of a single reload count.

Software reaches the core through a small 32-bit register interface with separate read and write strobes. A new time is not loaded at once. It is held in a staging register, and the next tick copies it into the current time. Until that tick, software can read the staged value back. Every tick raises a seconds flag, which software clears by writing a one to it. An enable bit in the control register routes the flag to an interrupt output. A write to the calibration register restarts the prescaler, so a following time write aligns to a full second.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, the current time, staged time, status and control all read 0, the interrupt output is 0, and calibration reads the default 0x198233.
- R2: A write to offset 0x00 stages a time without changing the current time (offset 0x10). The next tick copies the staged value into the current time.
- R3: Reading offset 0x04 returns the value last written to offset 0x00.
- R4: On a tick with no staged time pending, the current time increases by one modulo 2^32. Between ticks it holds.
- R5: Status bit 0 (offset 0x20) is set on every tick. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A tick in the same cycle as a clear keeps the flag set.
- R6: Calibration (offset 0x08) stores only bits [20:0] of the written word and reads back with bits [31:21] zero.
- R7: A calibration write clears the prescaler. The next tick falls exactly one full calibrated period of enables after the write.
- R8: With fractional correction off, the period is (cal[15:0] + 1) crystal enables. Clock cycles without an enable do not advance the prescaler.
- R9: When cal[20] is 1, seconds numbered below cal[19:16] in each group of 16 take one extra enable. Numbering restarts at 0 on a calibration write.
- R10: Control (offset 0x40) stores bit 31 (battery select, stored only) and bit 0 (interrupt enable). All other bits read 0. The interrupt output equals the seconds flag ANDed with bit 0.
- R11: An access to any other offset reads 0. A write to such an offset changes no register.
- R12: Read data appears on the output in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_en_i | input | 1 | One-cycle enable at crystal rate |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Seconds interrupt |

## Verification
The bench builds the core with its default widths: a 16-bit reload, a 4-bit fraction and a 32-bit time. At run time it programs a reload of 3, so one second lasts four enables. This puts every tick boundary, calibration realignment and fractional-stretch pattern within a few dozen cycles. Staging a time of all ones brings the 32-bit wrap within reach in two ticks. The fraction value 2 shows both stretched and unstretched seconds inside a single short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_SET_WR = 'h00;
  localparam int OFF_SET_RD = 'h04;
  localparam int OFF_CAL    = 'h08;
  localparam int OFF_CUR    = 'h10;
  localparam int OFF_STS    = 'h20;
  localparam int OFF_CTRL   = 'h40;
  localparam int CTRL_IRQ_EN_BIT = 0;
  localparam int CTRL_BATT_BIT   = 31;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int RELOAD_W = 16,
  parameter int FRAC_W   = 4,
  localparam int CAL_W   = RELOAD_W + FRAC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xtal_en_i,
  input  logic             cal_wr_i,
  input  logic [CAL_W-1:0] cal_i,
  output logic             tick_o
);
  logic [RELOAD_W:0]   cnt_q, limit;
  logic [FRAC_W-1:0]   sec_idx_q;
  logic [RELOAD_W-1:0] reload;
  logic [FRAC_W-1:0]   frac;
  logic                frac_en, extra;

  assign reload  = cal_i[RELOAD_W-1:0];
  assign frac    = cal_i[RELOAD_W +: FRAC_W];
  assign frac_en = cal_i[CAL_W-1];
  // stretch the first 'frac' seconds of each 2^FRAC_W group
  assign extra   = frac_en && (sec_idx_q < frac);
  assign limit   = {1'b0, reload} + {{RELOAD_W{1'b0}}, extra};
  assign tick_o  = xtal_en_i && !cal_wr_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sec_idx_q <= '0;
    end else if (cal_wr_i) begin
      cnt_q     <= '0;
      sec_idx_q <= '0;
    end else if (tick_o) begin
      cnt_q     <= '0;
      sec_idx_q <= sec_idx_q + 1'b1;
    end else if (xtal_en_i) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_i |=> (cnt_q == '0));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xtal_en_i && !cal_wr_i) |=> $stable(cnt_q));
  p_frac_idx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !cal_wr_i) |=> $stable(sec_idx_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              set_wr_i,
  input  logic [TIME_W-1:0] set_data_i,
  output logic [TIME_W-1:0] cur_o,
  output logic [TIME_W-1:0] set_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o  <= '0;
      set_o  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick_i) cur_o <= pend_q ? set_o : cur_o + 1'b1;
      // a write in a tick cycle stays pending for the following tick
      if (set_wr_i) begin
        set_o  <= set_data_i;
        pend_q <= 1'b1;
      end else if (tick_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cur_o));
  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pend_q) |=> (cur_o == $past(cur_o) + 1'b1));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q) |=> (cur_o == $past(set_o)));
endmodule

// File: rtl/rtc_csr.sv
module rtc_csr #(
  parameter int              TIME_W      = 32,
  parameter int              ADDR_W      = 8,
  parameter int              CAL_W       = 21,
  parameter logic [CAL_W-1:0] CAL_DEFAULT = 21'h198233
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] cur_i,
  input  logic [TIME_W-1:0] set_i,
  output logic              set_wr_o,
  output logic              cal_wr_o,
  output logic [CAL_W-1:0]  cal_o,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  logic flag_q, irq_en_q, batt_q, sts_clr;
  logic [31:0] rmux;

  assign set_wr_o = wr_en_i && (addr_i == ADDR_W'(OFF_SET_WR));
  assign cal_wr_o = wr_en_i && (addr_i == ADDR_W'(OFF_CAL));
  assign sts_clr  = wr_en_i && (addr_i == ADDR_W'(OFF_STS)) && wdata_i[0];
  assign irq_o    = flag_q && irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_o    <= CAL_DEFAULT;
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
      batt_q   <= 1'b0;
    end else begin
      if (cal_wr_o) cal_o <= wdata_i[CAL_W-1:0];
      if (tick_i)       flag_q <= 1'b1;
      else if (sts_clr) flag_q <= 1'b0;
      if (wr_en_i && addr_i == ADDR_W'(OFF_CTRL)) begin
        irq_en_q <= wdata_i[CTRL_IRQ_EN_BIT];
        batt_q   <= wdata_i[CTRL_BATT_BIT];
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (addr_i)
      ADDR_W'(OFF_SET_RD): rmux = 32'(set_i);
      ADDR_W'(OFF_CAL):    rmux = 32'(cal_o);
      ADDR_W'(OFF_CUR):    rmux = 32'(cur_i);
      ADDR_W'(OFF_STS):    rmux = {31'b0, flag_q};
      ADDR_W'(OFF_CTRL): begin
        rmux[CTRL_BATT_BIT]   = batt_q;
        rmux[CTRL_IRQ_EN_BIT] = irq_en_q;
      end
      default:             rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rmux;
  end

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_q);
  p_flag_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr && !tick_i) |=> !flag_q);
  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core #(
  parameter int   TIME_W      = 32,
  parameter int   ADDR_W      = 8,
  parameter int   RELOAD_W    = 16,
  parameter int   FRAC_W      = 4,
  parameter logic [RELOAD_W+FRAC_W:0] CAL_DEFAULT = 21'h198233
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int CAL_W = RELOAD_W + FRAC_W + 1;

  logic              tick, set_wr, cal_wr;
  logic [CAL_W-1:0]  cal;
  logic [TIME_W-1:0] cur, set_val;

  rtc_prescaler #(.RELOAD_W(RELOAD_W), .FRAC_W(FRAC_W)) u_presc (
    .clk_i, .rst_ni, .xtal_en_i, .cal_wr_i(cal_wr), .cal_i(cal), .tick_o(tick)
  );

  rtc_timekeeper #(.TIME_W(TIME_W)) u_time (
    .clk_i, .rst_ni, .tick_i(tick), .set_wr_i(set_wr),
    .set_data_i(wdata_i[TIME_W-1:0]), .cur_o(cur), .set_o(set_val)
  );

  rtc_csr #(.TIME_W(TIME_W), .ADDR_W(ADDR_W), .CAL_W(CAL_W),
            .CAL_DEFAULT(CAL_DEFAULT)) u_csr (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .tick_i(tick), .cur_i(cur), .set_i(set_val),
    .set_wr_o(set_wr), .cal_wr_o(cal_wr), .cal_o(cal),
    .rdata_o, .irq_o
  );

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ##0 (irq_o == $past(u_csr.irq_en_q)) || $past(wr_en_i));
endmodule

// File: tb/rtc_seconds_core_bench.sv
module rtc_seconds_core_bench;
  logic clk = 0, rst_n = 0;
  logic xtal_en = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;
  logic mon_vld = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rtc_seconds_core u_rtc_seconds_core (
    .clk_i(clk), .rst_ni(rst_n), .xtal_en_i(xtal_en), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: read data is due one edge after the strobe (R12)
  always @(posedge clk) mon_vld <= rd_en;
  always @(negedge clk) begin
    if (mon_vld && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s R12: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xtal_en = 1;
      @(negedge clk); xtal_en = 0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd('h10, 0, "R1 cur");
    rd('h20, 0, "R1 sts");
    rd('h08, 32'h198233, "R1 R6 cal default");
    rd('h40, 0, "R1 ctrl");
    rd('h04, 0, "R1 staged");
    chk_irq(0, "R1 irq");
    // R2 R3 staged set, period 4 enables
    wr('h08, 32'h3);
    wr('h00, 100);
    rd('h04, 100, "R3 readback");
    rd('h10, 0, "R2 not yet visible");
    pulse(3);
    rd('h10, 0, "R2 R8 before tick");
    pulse(1);
    rd('h10, 100, "R2 loaded on tick");
    rd('h20, 1, "R5 flag set");
    pulse(4);
    rd('h10, 101, "R4 R8 increment");
    // R7 realign
    pulse(2);
    wr('h08, 32'h3);
    pulse(3);
    rd('h10, 101, "R7 no early tick");
    pulse(1);
    rd('h10, 102, "R7 full period");
    // R5 W1C
    wr('h20, 0);
    rd('h20, 1, "R5 write 0 keeps");
    wr('h20, 1);
    rd('h20, 0, "R5 write 1 clears");
    // R10 control / irq
    wr('h40, 1);
    chk_irq(0, "R10 irq no flag");
    pulse(4);
    chk_irq(1, "R10 irq flag&en");
    wr('h40, 32'hFFFF_FFFF);
    rd('h40, 32'h8000_0001, "R10 stored bits");
    wr('h40, 32'h8000_0000);
    chk_irq(0, "R10 irq disabled");
    // R11 unmapped
    wr('h14, 32'hDEAD_BEEF);
    wr('h0C, 32'h7);
    rd('h14, 0, "R11 read 0x14");
    rd('h0C, 0, "R11 read 0x0C");
    rd('h10, 103, "R11 cur untouched");
    rd('h08, 3, "R11 cal untouched");
    // R4 wrap
    wr('h00, 32'hFFFF_FFFF);
    pulse(4);
    rd('h10, 32'hFFFF_FFFF, "R2 load all ones");
    pulse(4);
    rd('h10, 0, "R4 wrap");
    // R9 fractional: frac 2, reload 3
    wr('h08, 32'h0012_0003);
    pulse(4);
    rd('h10, 0, "R9 sec0 stretched");
    pulse(1);
    rd('h10, 1, "R9 sec0 tick");
    pulse(4);
    rd('h10, 1, "R9 sec1 stretched");
    pulse(1);
    rd('h10, 2, "R9 sec1 tick");
    pulse(4);
    rd('h10, 3, "R9 sec2 normal");
    // R6 mask
    wr('h08, 32'hFFFF_FFFF);
    rd('h08, 32'h001F_FFFF, "R6 mask");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule